// File: doc/BRIEF.md
# Prescaled Free-Running Timer

A 32-bit register-mapped up-counter for a system clock domain. Software picks the count source in a control word: either every cycle of the bus clock, or a slow oscillator that arrives as a one-cycle tick enable synchronous to that clock. On the oscillator path the tick first passes an oscillator divider and then the main divider. On the bus-clock path only the main divider is used. Setting a field to N divides by N+1.

Three compare registers set sticky status flags when the counter reaches their value. A rollover of the counter sets a further flag. Status bits clear when 1 is written to them. The single interrupt line is the registered OR of the status bits that are enabled. Two modes are available. In free-run mode the count wraps at its maximum. In restart mode the count returns to zero after it reaches compare 1. A self-clearing soft reset bit lets software return the timer to a known state and poll for the end of that reset.

Top module: `prescaled_timer`

## Requirements
- R1: After the synchronous reset every word reads 0 and `irq` is 0.
- R2: The words sit at byte offsets: control 0x00, prescaler 0x04, status 0x08, interrupt enable 0x0C, compares 1..3 at 0x10/0x14/0x18, two capture words at 0x1C/0x20 that always read 0, and the counter at 0x24. The counter word is read-only, so writing it has no effect.
- R3: Control fields are: bit 0 count enable, bits [8:6] source, bit 9 free-run, bit 10 oscillator enable, bit 15 soft reset. With source 1 and the enable set, the counter advances once every (P[11:0]+1) clocks, where P is the prescaler word.
- R4: With source 5 and bit 10 set, the counter advances once per (P[15:12]+1)*(P[11:0]+1) oscillator ticks. With bit 10 clear, or with any source value other than 1 or 5, the counter does not advance.
- R5: While bit 0 is clear the counter holds its value. Setting bit 0 again resumes counting from the held value.
- R6: In free-run mode (bit 9 = 1) the counter counts past compare 1 and wraps from its maximum to 0. The wrap sets status bit 5.
- R7: In restart mode (bit 9 = 0) the counter steps through 0,1,...,C and then returns to 0, where C is the value of compare 1.
- R8: When the counter takes a value equal to compare N, status bit N-1 is set (bits 0, 1, 2).
- R9: Writing 1 to a status bit clears it. Writing 0 leaves the bit unchanged. An event in the same cycle as the write wins over the clear.
- R10: `irq` rises one cycle after some status bit and its matching enable bit (same position) are both 1. It falls once no such pair remains.
- R11: Writing 1 to control bit 15 starts a soft reset. Bit 15 reads 1 for the next 2 cycles and then reads 0. The soft reset clears the counter, the divider state, status and all other control bits. The compare, prescaler and interrupt-enable words keep their values. Writes to control during the soft reset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and count clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle oscillator tick, synchronous to clk |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 6 | Byte address, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered, valid one cycle after rd_en |
| irq | output | 1 | Registered interrupt request |

## Verification
A write takes effect at the clock edge that samples it. The counter can step at that same edge at the earliest, and it is read back through `rdata` one edge after `rd_en`. Each rate check therefore reads the counter twice, with the two sampling edges a whole number of divider periods apart. The difference between the two reads is then exact whatever the divider phase is. The soft-reset bit is read on the first, second and third edge after the write, so its length is checked cycle by cycle. `irq` is sampled at least two edges after the status or enable change, which allows for the extra register on the way to the pin.

// File: rtl/timer_pkg.sv
package timer_pkg;
  // word indices (byte offset / 4)
  localparam int W_CTRL = 0;
  localparam int W_PRE  = 1;
  localparam int W_STAT = 2;
  localparam int W_IE   = 3;
  localparam int W_CMP0 = 4;
  localparam int W_CNT  = 9;

  // control bit positions
  localparam int B_EN   = 0;
  localparam int B_SRC  = 6;
  localparam int B_FREE = 9;
  localparam int B_OSC  = 10;
  localparam int B_SWR  = 15;

  localparam logic [2:0] SRC_PERIPH = 3'd1;
  localparam logic [2:0] SRC_OSC    = 3'd5;

  // status layout
  localparam int STAT_W  = 6;
  localparam int ST_WRAP = 5;
endpackage

// File: rtl/timer_prescale.sv
module timer_prescale #(
  parameter int MAIN_W = 12,
  parameter int OSC_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              run,
  input  logic              use_periph,
  input  logic              use_osc,
  input  logic              osc_tick,
  input  logic [MAIN_W-1:0] main_div,
  input  logic [OSC_W-1:0]  osc_div,
  output logic              tick
);
  logic [OSC_W-1:0]  osc_cnt;
  logic [MAIN_W-1:0] main_cnt;
  logic osc_last, stage1, main_last;

  assign osc_last  = osc_cnt >= osc_div;
  assign stage1    = use_osc ? (osc_tick && osc_last) : use_periph;
  assign main_last = main_cnt >= main_div;
  assign tick      = run && stage1 && main_last;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      osc_cnt  <= '0;
      main_cnt <= '0;
    end else if (run) begin
      if (use_osc && osc_tick)
        osc_cnt <= osc_last ? '0 : osc_cnt + 1'b1;
      if (stage1)
        main_cnt <= main_last ? '0 : main_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int CNT_W   = 32,
  parameter int NUM_CMP = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            clr,
  input  logic                            tick,
  input  logic                            restart,
  input  logic [NUM_CMP-1:0][CNT_W-1:0]   cmp,
  output logic [CNT_W-1:0]                count,
  output logic [NUM_CMP-1:0]              match_set,
  output logic                            wrap_set
);
  logic [CNT_W-1:0] nxt;

  assign nxt      = (restart && count == cmp[0]) ? '0 : count + 1'b1;
  assign wrap_set = tick && (&count);

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    assign match_set[g] = tick && (nxt == cmp[g]);
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      count <= '0;
    else if (tick)
      count <= nxt;
  end
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import timer_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 6,
  parameter int CNT_W      = 32,
  parameter int NUM_CMP    = 3,
  parameter int MAIN_W     = 12,
  parameter int OSC_W      = 4,
  parameter int SWR_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int LEFT_W = $clog2(SWR_CYCLES + 1);
  localparam logic [STAT_W-1:0] STAT_MASK =
    STAT_W'((1 << NUM_CMP) - 1) | (STAT_W'(1) << ST_WRAP);

  logic [WORD_W-1:0] word;
  logic              en_q, free_q, osc_on_q;
  logic [2:0]        src_q;
  logic [LEFT_W-1:0] swr_left;
  logic              busy;
  logic [MAIN_W-1:0] pre_main_q;
  logic [OSC_W-1:0]  pre_osc_q;
  logic [STAT_W-1:0] status_q, ie_q, set_mask, clr_mask;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0]  count;
  logic [NUM_CMP-1:0] match_set;
  logic              wrap_set, cnt_tick;
  logic [DATA_W-1:0] ctrl_rd, rd_val;

  assign word = addr[ADDR_W-1:2];
  assign busy = swr_left != '0;

  timer_prescale #(.MAIN_W(MAIN_W), .OSC_W(OSC_W)) u_pre (
    .clk        (clk),
    .rst        (rst),
    .clr        (busy),
    .run        (en_q),
    .use_periph (src_q == SRC_PERIPH),
    .use_osc    ((src_q == SRC_OSC) && osc_on_q),
    .osc_tick   (osc_tick),
    .main_div   (pre_main_q),
    .osc_div    (pre_osc_q),
    .tick       (cnt_tick)
  );

  timer_counter #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .clr       (busy),
    .tick      (cnt_tick),
    .restart   (!free_q),
    .cmp       (cmp_q),
    .count     (count),
    .match_set (match_set),
    .wrap_set  (wrap_set)
  );

  always_comb begin
    set_mask = '0;
    set_mask[NUM_CMP-1:0] = match_set;
    set_mask[ST_WRAP]     = wrap_set;
    clr_mask = (wr_en && int'(word) == W_STAT) ? wdata[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; free_q <= 1'b0; osc_on_q <= 1'b0; src_q <= '0;
      swr_left <= '0;
      pre_main_q <= '0; pre_osc_q <= '0;
      status_q <= '0; ie_q <= '0; cmp_q <= '0;
    end else begin
      status_q <= ((status_q & ~clr_mask) | set_mask) & STAT_MASK;
      if (busy) begin
        swr_left <= swr_left - 1'b1;
        en_q <= 1'b0; free_q <= 1'b0; osc_on_q <= 1'b0; src_q <= '0;
        status_q <= '0;
      end else if (wr_en && int'(word) == W_CTRL) begin
        if (wdata[B_SWR]) begin
          swr_left <= LEFT_W'(SWR_CYCLES);
          en_q <= 1'b0; free_q <= 1'b0; osc_on_q <= 1'b0; src_q <= '0;
        end else begin
          en_q     <= wdata[B_EN];
          free_q   <= wdata[B_FREE];
          osc_on_q <= wdata[B_OSC];
          src_q    <= wdata[B_SRC +: 3];
        end
      end
      if (wr_en && int'(word) == W_PRE) begin
        pre_main_q <= wdata[MAIN_W-1:0];
        pre_osc_q  <= wdata[MAIN_W +: OSC_W];
      end
      if (wr_en && int'(word) == W_IE)
        ie_q <= wdata[STAT_W-1:0] & STAT_MASK;
      for (int i = 0; i < NUM_CMP; i++)
        if (wr_en && int'(word) == W_CMP0 + i)
          cmp_q[i] <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[B_EN]       = en_q;
    ctrl_rd[B_SRC +: 3] = src_q;
    ctrl_rd[B_FREE]     = free_q;
    ctrl_rd[B_OSC]      = osc_on_q;
    ctrl_rd[B_SWR]      = busy;
    case (int'(word))
      W_CTRL:  rd_val = ctrl_rd;
      W_PRE:   rd_val = DATA_W'({pre_osc_q, pre_main_q});
      W_STAT:  rd_val = DATA_W'(status_q);
      W_IE:    rd_val = DATA_W'(ie_q);
      W_CNT:   rd_val = DATA_W'(count);
      default: rd_val = '0;
    endcase
    for (int i = 0; i < NUM_CMP; i++)
      if (int'(word) == W_CMP0 + i)
        rd_val = DATA_W'(cmp_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_val;
      irq <= |(status_q & ie_q);
    end
  end
endmodule

// File: rtl/timer_chk.sv
module timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             restart,
  input logic             en,
  input logic             busy,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cmp1,
  input logic [5:0]       status,
  input logic [5:0]       ie,
  input logic             irq
);
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!en && !busy) |=> $stable(count)); // R5
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
    (tick && (&count)) |=> status[5]); // R6
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tick && restart && count == cmp1) |=> count == '0); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past((status & ie) != 6'd0)); // R10
  AST_SWR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    busy |=> (count == '0 && status == 6'd0)); // R11
  AST_SWR_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy); // R11
endmodule

bind prescaled_timer timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (cnt_tick),
  .restart (!free_q),
  .en      (en_q),
  .busy    (busy),
  .count   (count),
  .cmp1    (cmp_q[0]),
  .status  (status_q),
  .ie      (ie_q),
  .irq     (irq)
);

// File: tb/prescaled_timer_test.sv
module prescaled_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        osc_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int total = 0;
  int bad = 0;
  int osc_ph = 0;

  localparam logic [5:0] A_CTRL = 6'h00, A_PRE = 6'h04, A_STAT = 6'h08,
    A_IE = 6'h0C, A_CMP1 = 6'h10, A_CMP2 = 6'h14, A_CMP3 = 6'h18,
    A_CAP1 = 6'h1C, A_CAP2 = 6'h20, A_CNT = 6'h24;

  prescaled_timer #(.CNT_W(12)) uut (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #4 clk = ~clk;

  // oscillator tick: one clock high in every three
  always @(negedge clk) begin
    osc_ph   <= (osc_ph == 2) ? 0 : osc_ph + 1;
    osc_tick <= (osc_ph == 2);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(posedge clk); #1; d = rdata; rd_en = 1'b0;
  endtask

  task automatic soft_reset();
    wr(A_CTRL, 32'h8000);
    repeat (4) @(posedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 10; i++) begin
      rd(6'(i * 4), v);
      check("R1 word after reset", v, 32'h0);
    end
    check("R1 irq after reset", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(A_CMP2, 32'hFFFF_FABC);
    wr(A_CNT, 32'h123);
    rd(A_CNT, v);  check("R2 counter write ignored", v, 32'h0);
    rd(A_CAP1, v); check("R2 capture1 reads 0", v, 32'h0);
    rd(A_CAP2, v); check("R2 capture2 reads 0", v, 32'h0);
    rd(A_CMP2, v); check("R2 compare2 at 0x14", v, 32'hABC);
    rd(A_CMP3, v); check("R2 compare3 untouched", v, 32'h0);
    wr(A_CMP2, 32'hFFF);
  endtask

  task automatic t_periph();
    logic [31:0] a, b;
    soft_reset();
    wr(A_PRE, 32'd3);
    wr(A_CTRL, 32'h241);
    rd(A_CNT, a); repeat (39) @(posedge clk); rd(A_CNT, b);
    check("R3 periph div4 over 40", b - a, 32'd10);
    wr(A_PRE, 32'd0);
    rd(A_CNT, a); repeat (19) @(posedge clk); rd(A_CNT, b);
    check("R3 periph div1 over 20", b - a, 32'd20);
  endtask

  task automatic t_osc();
    logic [31:0] a, b;
    soft_reset();
    wr(A_PRE, (32'd1 << 12) | 32'd2);
    wr(A_CTRL, 32'h741);
    rd(A_CNT, a); repeat (179) @(posedge clk); rd(A_CNT, b);
    check("R4 osc cascade over 180", b - a, 32'd10);
    wr(A_CTRL, 32'h341);
    rd(A_CNT, a); repeat (29) @(posedge clk); rd(A_CNT, b);
    check("R4 osc enable clear stops", b - a, 32'd0);
    wr(A_CTRL, 32'h201);
    rd(A_CNT, a); repeat (29) @(posedge clk); rd(A_CNT, b);
    check("R4 source 0 stops", b - a, 32'd0);
    wr(A_PRE, 32'd0);
  endtask

  task automatic t_hold();
    logic [31:0] a, b, c, d;
    soft_reset();
    wr(A_CTRL, 32'h241);
    repeat (10) @(posedge clk);
    wr(A_CTRL, 32'h240);
    rd(A_CNT, a); repeat (19) @(posedge clk); rd(A_CNT, b);
    check("R5 held while disabled", b, a);
    check("R5 had counted", {31'h0, a != 0}, 32'h1);
    wr(A_CTRL, 32'h241);
    rd(A_CNT, c); repeat (9) @(posedge clk); rd(A_CNT, d);
    check("R5 resumes from held", {31'h0, c >= b && c - b <= 3}, 32'h1);
    check("R5 rate after resume", d - c, 32'd10);
  endtask

  task automatic t_restart();
    logic [31:0] prev, cur;
    soft_reset();
    wr(A_CMP1, 32'd4);
    wr(A_CTRL, 32'h041);
    repeat (3) @(posedge clk);
    rd(A_CNT, prev);
    for (int i = 0; i < 12; i++) begin
      rd(A_CNT, cur);
      check("R7 restart sequence", cur, (prev == 32'd4) ? 32'd0 : prev + 32'd1);
      prev = cur;
    end
  endtask

  task automatic t_compare_irq();
    logic [31:0] s;
    soft_reset();
    wr(A_CMP1, 32'd100);
    wr(A_CMP2, 32'd7);
    wr(A_CMP3, 32'd9);
    wr(A_IE, 32'h2);
    wr(A_CTRL, 32'h241);
    repeat (20) @(posedge clk);
    wr(A_CTRL, 32'h240);
    repeat (2) @(posedge clk);
    rd(A_STAT, s);
    check("R8 compare2/3 flags only", s, 32'h6);
    check("R10 irq with enabled flag", {31'h0, irq}, 32'h1);
    wr(A_STAT, 32'h2);
    wr(A_STAT, 32'h0);
    rd(A_STAT, s);
    check("R9 write-one clears, zero keeps", s, 32'h4);
    #1;
    check("R10 irq low after clear", {31'h0, irq}, 32'h0);
    wr(A_IE, 32'h4);
    repeat (2) @(posedge clk); #1;
    check("R10 irq from compare3 enable", {31'h0, irq}, 32'h1);
    wr(A_IE, 32'h0);
  endtask

  task automatic t_wrap();
    logic [31:0] a, s;
    soft_reset();
    wr(A_CMP1, 32'd5);
    wr(A_CTRL, 32'h241);
    repeat (20) @(posedge clk);
    rd(A_CNT, a);
    check("R6 counts past compare1", {31'h0, a > 32'd5}, 32'h1);
    repeat (4100) @(posedge clk);
    wr(A_CTRL, 32'h240);
    rd(A_STAT, s);
    check("R6 wrap and R8 compare1 flags", s & 32'h21, 32'h21);
    rd(A_CNT, a);
    check("R6 counter wrapped", {31'h0, a < 32'd100}, 32'h1);
    wr(A_STAT, 32'h20);
    rd(A_STAT, s);
    check("R9 clear wrap flag only", s & 32'h21, 32'h01);
  endtask

  task automatic t_swr();
    logic [31:0] v;
    wr(A_CMP1, 32'h55);
    wr(A_PRE, 32'h1003);
    wr(A_IE, 32'h1);
    wr(A_CTRL, 32'h241);
    repeat (10) @(posedge clk);
    wr(A_CTRL, 32'h8000);
    rd(A_CTRL, v); check("R11 busy cycle 1", v, 32'h8000);
    rd(A_CTRL, v); check("R11 busy cycle 2", v, 32'h8000);
    rd(A_CTRL, v); check("R11 self cleared", v, 32'h0);
    rd(A_CNT, v);  check("R11 counter cleared", v, 32'h0);
    rd(A_STAT, v); check("R11 status cleared", v, 32'h0);
    rd(A_CMP1, v); check("R11 compare kept", v, 32'h55);
    rd(A_PRE, v);  check("R11 prescaler kept", v, 32'h1003);
    rd(A_IE, v);   check("R11 enable mask kept", v, 32'h1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_map();
    t_periph();
    t_osc();
    t_hold();
    t_restart();
    t_compare_irq();
    t_wrap();
    t_swr();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule